// File: doc/BRIEF.md
# Two-Stage Cascade Sigma-Delta Decimator

This block is the digital back end of a 2-1 cascaded sigma-delta converter. On every modulator clock it receives two single-bit streams: a coarse stream from a second-order loop and a fine stream from a first-order loop that digitises the coarse loop's quantisation error. A small shift-and-add network joins the two streams into one signed word. In that word the coarse-stage quantisation error is cancelled and only third-order shaped noise is left.

The joined word feeds a multiplier-free fourth-order cascaded integrator-comb filter. Its integrators run at the modulator rate. A rate-64 downsampler follows, and then four comb sections run at the output rate. The full-precision result is rounded to a 14-bit signed sample, and a one-cycle strobe marks each new sample. With a 25.6 MHz modulator clock the block delivers 400 kSPS.

Top module: `mash_decim`

## Requirements
- R1: Each input bit maps to +1 when 1 and to -1 when 0. The joined word is w[n] = C[n-1] + F[n] - 2*F[n-1] + F[n-2], where C is the coarse stream and F the fine stream. History from before reset counts as 0.
- R2: The joined word always lies in the range -5 to +5 and is carried as a 4-bit signed value.
- R3: Clock edges are counted from 0, starting at the first edge after reset is released. For an output strobed after edge N, the sample equals floor((Y + 8192) / 16384), where Y = sum over k of w[k]*h[N-4-k] and h is the 253-tap kernel of ((1 - z^-64)/(1 - z^-1))^4, i.e. four length-64 boxcars convolved together.
- R4: sample_vld is high for exactly one cycle after each edge N = 63 + 64*m, and low in every other cycle.
- R5: sample_o keeps its value in every cycle in which sample_vld is low.
- R6: The DC gain is 1024 output codes per unit of mean coarse level. Constant ones settle to +1024, constant zeros settle to -1024, and an alternating coarse stream settles to 0. Any fine stream adds no DC.
- R7: A synchronous reset clears all delay, integrator and comb state and the rate counter. While reset is held and right after it, sample_o is 0 and sample_vld is 0. The next strobe comes after edge 63, counted from the release.
- R8: Internal registers are 28 bits wide and wrap in two's complement. Outputs stay exact per R3 over runs far longer than the point where the integrators overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| coarse_bit | input | 1 | Bit from the second-order first loop |
| fine_bit | input | 1 | Bit from the first-order second loop |
| sample_o | output | 14 | Rounded signed output sample |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
The assertions assume that both bitstreams are clean 0/1 values at every sampling edge and that reset is held for at least two edges, so that the hold check starts from a cleared sample register. The range check on the joined word needs no assumption, because any bit pattern keeps it within +/-5. The bench drives inputs on the falling edge and holds reset for four edges. Its stimulus comes from constant and alternating patterns and from a behavioural two-stage modulator kept at low input levels, where the coarse loop stays bounded.

// File: rtl/mash_decim_pkg.sv
package mash_decim_pkg;
    localparam int unsigned DEF_RATE  = 64;
    localparam int unsigned DEF_ORDER = 4;
    localparam int unsigned DEF_OUT_W = 14;
    localparam int unsigned CANCEL_W  = 4;

    // Signed level of one bit: -1, 0 (cleared history) or +1
    typedef logic signed [1:0] pm_t;

    function automatic pm_t bit_to_pm(input logic b);
        return b ? 2'sb01 : 2'sb11;
    endfunction
endpackage

// File: rtl/mash_cancel.sv
module mash_cancel
    import mash_decim_pkg::*;
#(
    parameter int unsigned W = CANCEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coarse_bit,
    input  logic                fine_bit,
    output logic signed [W-1:0] word_o
);
    typedef struct packed {
        pm_t c1;
        pm_t f1;
        pm_t f2;
    } hist_t;

    hist_t st_q, st_d;
    pm_t   c_now, f_now;

    always_comb begin
        c_now   = bit_to_pm(coarse_bit);
        f_now   = bit_to_pm(fine_bit);
        st_d.c1 = c_now;
        st_d.f1 = f_now;
        st_d.f2 = st_q.f1;
        // delayed coarse level plus second difference of the fine level
        word_o  = W'(st_q.c1) + W'(f_now) - (W'(st_q.f1) <<< 1) + W'(st_q.f2);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    word_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(word_o) >= -5) && (int'(word_o) <= 5));
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
    parameter int unsigned IN_W  = 4,
    parameter int unsigned ORDER = 4,
    parameter int unsigned ACC_W = 28
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] din,
    output logic [ACC_W-1:0]       dout
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t           st_q, st_d;
    logic [ACC_W-1:0] feed [ORDER];

    for (genvar i = 0; i < ORDER; i++) begin : g_feed
        if (i == 0) begin : g_head
            assign feed[i] = ACC_W'(din);
        end else begin : g_tail
            assign feed[i] = st_q.acc[i-1];
        end
    end

    always_comb begin
        for (int i = 0; i < ORDER; i++) begin
            st_d.acc[i] = st_q.acc[i] + feed[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.acc[ORDER-1];

    // R7
    integ_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.acc == '0));
endmodule

// File: rtl/cic_comb_dec.sv
module cic_comb_dec #(
    parameter int unsigned RATE  = 64,
    parameter int unsigned ORDER = 4,
    parameter int unsigned ACC_W = 28,
    parameter int unsigned OUT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        din,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    sample_vld
);
    localparam int unsigned      CNT_W = $clog2(RATE);
    localparam int unsigned      DROP  = ACC_W - OUT_W;
    localparam logic [ACC_W-1:0] HALF  = ACC_W'(1) << (DROP - 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(RATE - 1);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [ORDER-1:0][ACC_W-1:0] dly;
        logic [OUT_W-1:0]            smp;
        logic                        vld;
    } dec_t;

    dec_t             st_q, st_d;
    logic [ACC_W-1:0] stg [ORDER+1];
    logic             tick;

    assign stg[0] = din;
    for (genvar i = 0; i < ORDER; i++) begin : g_comb
        assign stg[i+1] = stg[i] - st_q.dly[i];
    end

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.cnt == LAST);
        st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        st_d.vld = tick;
        if (tick) begin
            for (int i = 0; i < ORDER; i++) begin
                st_d.dly[i] = stg[i];
            end
            st_d.smp = OUT_W'((stg[ORDER] + HALF) >> DROP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sample_o   = st_q.smp;
    assign sample_vld = st_q.vld;

    // R4
    vld_single_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |=> !st_q.vld);

    // R4
    vld_phase_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |-> ($past(st_q.cnt) == LAST));

    // R5
    smp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.vld |-> $stable(st_q.smp));

    // R7
    dec_clear_chk: assert property (@(posedge clk)
        rst |=> ((st_q.cnt == '0) && !st_q.vld && (st_q.smp == '0)));
endmodule

// File: rtl/mash_decim.sv
module mash_decim
    import mash_decim_pkg::*;
#(
    parameter int unsigned RATE  = DEF_RATE,
    parameter int unsigned ORDER = DEF_ORDER,
    parameter int unsigned OUT_W = DEF_OUT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    coarse_bit,
    input  logic                    fine_bit,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    sample_vld
);
    localparam int unsigned GROWTH = ORDER * $clog2(RATE);
    localparam int unsigned ACC_W  = CANCEL_W + GROWTH;

    logic signed [CANCEL_W-1:0] word;
    logic [ACC_W-1:0]           integ_out;

    mash_cancel #(.W(CANCEL_W)) u_cancel (
        .clk        (clk),
        .rst        (rst),
        .coarse_bit (coarse_bit),
        .fine_bit   (fine_bit),
        .word_o     (word)
    );

    cic_integ #(.IN_W(CANCEL_W), .ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk  (clk),
        .rst  (rst),
        .din  (word),
        .dout (integ_out)
    );

    cic_comb_dec #(.RATE(RATE), .ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .din        (integ_out),
        .sample_o   (sample_o),
        .sample_vld (sample_vld)
    );
endmodule

// File: tb/mash_decim_bench.sv
`timescale 1ns/1ps
module mash_decim_bench;
    localparam int RATE   = 64;
    localparam int KLEN   = 253;
    localparam int SHIFT  = 14;
    localparam int SETTLE = 4;
    localparam int OUTS   = 24;
    localparam int FS     = 1024;
    localparam int ROWS   = 6;
    // columns: mode, modulator input, expected settled sample, tolerance
    // mode 0 ones/ones, 1 zeros/zeros, 2 coarse alternating/fine zero,
    // 3 behavioural modulator, 4 coarse ones/fine alternating
    localparam int VEC [ROWS][4] = '{
        '{0,    0,  1024,  0},
        '{1,    0, -1024,  0},
        '{2,    0,     0,  0},
        '{4,    0,  1024,  0},
        '{3,  300,   300, 24},
        '{3, -200,  -200, 24}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coarse_bit = 1'b0;
    logic fine_bit = 1'b0;
    logic signed [13:0] sample_o;
    logic sample_vld;
    bit done = 1'b0;

    int checks = 0;
    int fails = 0;
    longint h [KLEN];
    longint tmp [KLEN];
    int ahist [2048];
    int bhist [2048];
    int ehist [2048];
    int ep1, ep2, fe, e1d;

    always #4 clk = ~clk;

    mash_decim u_mash_decim (
        .clk        (clk),
        .rst        (rst),
        .coarse_bit (coarse_bit),
        .fine_bit   (fine_bit),
        .sample_o   (sample_o),
        .sample_vld (sample_vld)
    );

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        coarse_bit = 1'b0;
        fine_bit = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(sample_vld == 1'b0, "R7 strobe after reset", sample_vld, 0);
        check(int'(sample_o) == 0, "R7 sample after reset", int'(sample_o), 0);
    endtask

    function automatic longint ref_out(input int m);
        longint y = 0;
        for (int i = 0; i < KLEN; i++) begin
            if (m - i >= 0) y += h[i] * ehist[m-i];
        end
        return (y + 64'sd8192) >>> SHIFT;
    endfunction

    task automatic mod_step(input int x, output bit ca, output bit fb);
        int u, y, u2, y2, x2;
        u = x - 2*ep1 + ep2;
        y = (u >= 0) ? FS : -FS;
        ep2 = ep1;
        ep1 = y - u;
        ca = (u >= 0);
        x2 = -e1d / 2;
        u2 = x2 - fe;
        y2 = (u2 >= 0) ? FS : -FS;
        fe = y2 - u2;
        fb = (u2 >= 0);
        e1d = ep1;
    endtask

    task automatic run_row(input int mode, input int x, input int expv, input int tol, input bit with_rst);
        int last = 0;
        int hold_bad = 0;
        int vld_bad = 0;
        bit ca, fb, vexp;
        if (with_rst) do_reset();
        ep1 = 0; ep2 = 0; fe = 0; e1d = 0;
        for (int n = 0; n < OUTS*RATE; n++) begin
            case (mode)
                0: begin ca = 1'b1; fb = 1'b1; end
                1: begin ca = 1'b0; fb = 1'b0; end
                2: begin ca = (n % 2 == 0); fb = 1'b0; end
                4: begin ca = 1'b1; fb = (n % 2 == 1); end
                default: mod_step(x, ca, fb);
            endcase
            coarse_bit = ca;
            fine_bit = fb;
            ahist[n] = ca ? 1 : -1;
            bhist[n] = fb ? 1 : -1;
            ehist[n] = ((n >= 1) ? ahist[n-1] : 0) + bhist[n]
                     - 2*((n >= 1) ? bhist[n-1] : 0) + ((n >= 2) ? bhist[n-2] : 0);
            @(posedge clk);
            @(negedge clk);
            vexp = ((n % RATE) == RATE - 1);
            if (vexp) begin
                check(sample_vld == 1'b1, "R4 strobe at decimation edge", sample_vld, 1);
                if (n / RATE >= SETTLE) begin
                    longint r = ref_out(n - 4);
                    check(longint'(sample_o) == r, "R1 R3 R8 sample value", longint'(sample_o), r);
                end
                last = int'(sample_o);
            end else begin
                if (sample_vld != 1'b0) vld_bad++;
                if (int'(sample_o) != last) hold_bad++;
            end
        end
        check(vld_bad == 0, "R4 strobe outside decimation edges", vld_bad, 0);
        check(hold_bad == 0, "R5 sample hold between strobes", hold_bad, 0);
        check((last >= expv - tol) && (last <= expv + tol), "R6 settled level", last, expv);
    endtask

    initial begin
        for (int i = 0; i < KLEN; i++) h[i] = (i < RATE) ? 1 : 0;
        for (int r = 1; r < 4; r++) begin
            for (int i = 0; i < KLEN; i++) begin
                tmp[i] = 0;
                for (int j = 0; j < RATE; j++) begin
                    if (i - j >= 0) tmp[i] += h[i-j];
                end
            end
            for (int i = 0; i < KLEN; i++) h[i] = tmp[i];
        end

        // table walk
        for (int r = 0; r < ROWS; r++) begin
            run_row(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], 1'b1);
        end

        // directed: reset in mid-window clears state and rate counter (R7)
        do_reset();
        coarse_bit = 1'b1;
        fine_bit = 1'b1;
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(int'(sample_o) > 0, "R7 nonzero sample before reset", int'(sample_o), 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(int'(sample_o) == 0, "R7 sample cleared in reset", int'(sample_o), 0);
        check(sample_vld == 1'b0, "R7 strobe low in reset", sample_vld, 0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        run_row(1, 0, -1024, 0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule